// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block gathers the interrupt requests of a USB OTG core into a single word and presents one interrupt line to the CPU. Per-endpoint transmit and receive requests and the core's bus events arrive as input vectors. The rising edge of any input latches a bit in a raw source word. Software can also force source bits and acknowledge them through dedicated set and clear addresses. A separate enable word is edited the same way, so one bit can change without a read-modify-write.

The CPU line follows the source word ANDed with the enable word, but the line is gated. Once raised, it stays high until software writes the end-of-interrupt address, whatever happens to the sources in between. After that write the line drops for one cycle. It rises again on the following cycle if any enabled source is still pending, so no request is lost and a request cannot cause a second interrupt before its acknowledgement.

Access is through a 32-bit register port with byte addresses. Writes take effect at the clock edge. Read data is combinational from the current state.

Top module: `usb_irq_wrap`

## Requirements
- R1: After reset the raw source word, the enable word and the masked word all read 0, and `irq_o` is low.
- R2: A rising edge on `tx_evt_i[i]` sets source bit i (bits 4:0). A rising edge on `rx_evt_i[j]` sets bit 9+j (bits 12:9). A rising edge on `core_evt_i[k]` sets bit 16+k (bits 24:16). An input held high does not set its bit again after the bit is cleared.
- R3: A write to address 0x24 sets every source bit written as 1. Bits 5-8, 13-15 and 25-31 never become set and always read 0.
- R4: A write to address 0x28 clears every source bit written as 1 and leaves bits written as 0 unchanged.
- R5: When an input edge and a 0x28 clear hit the same source bit in the same cycle, the bit ends up set.
- R6: A write to 0x30 sets and a write to 0x34 clears exactly the enable bits written as 1. Zeros have no effect, and the unused bit positions of R3 read 0.
- R7: Address 0x20 reads the raw source word, 0x2C reads the enable word and 0x38 reads their AND. Addresses 0x24, 0x28, 0x30, 0x34 and 0x3C read 0.
- R8: With the line armed, `irq_o` rises one cycle after the masked word becomes nonzero. It then stays high, even if the sources are cleared, until an end-of-interrupt write. Unmasked sources never raise it.
- R9: A write to address 0x3C drives `irq_o` low in the following cycle. The line rises again one cycle later if a masked bit is pending; otherwise it stays low until one becomes pending.
- R10: The data written to address 0x3C is ignored. Any value has the same effect on the line and leaves the source and enable words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 when no read is strobed |
| tx_evt_i | input | 5 | Transmit endpoint requests (endpoint 0 to 4) |
| rx_evt_i | input | 4 | Receive endpoint requests (endpoint 1 to 4) |
| core_evt_i | input | 9 | Core bus events, top bit is the VBUS-drive change |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
Every bit position is driven one at a time through the event inputs and through the set address. Walking all 32 positions separates the valid field layout from the holes, and walking each input separately catches a swapped or shifted field. The enable word gets an accumulating walk followed by alternating clears, which shows that zeros are ignored. The line is tried with a source that is cleared before acknowledgement, an acknowledgement with nothing pending, an acknowledgement while still pending, and acknowledgement values of all zeros and all ones. These cases separate a level-following line from a gated one and check the one-cycle gap between acknowledgement and re-assertion.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  localparam logic [AW-1:0] OFS_RAW    = 8'h20;
  localparam logic [AW-1:0] OFS_SET    = 8'h24;
  localparam logic [AW-1:0] OFS_CLR    = 8'h28;
  localparam logic [AW-1:0] OFS_MASK   = 8'h2c;
  localparam logic [AW-1:0] OFS_MSET   = 8'h30;
  localparam logic [AW-1:0] OFS_MCLR   = 8'h34;
  localparam logic [AW-1:0] OFS_MASKED = 8'h38;
  localparam logic [AW-1:0] OFS_EOI    = 8'h3c;

  typedef struct packed {
    logic raw_set;
    logic raw_clr;
    logic msk_set;
    logic msk_clr;
    logic eoi;
  } wr_strb_t;

  function automatic logic [DW-1:0] field_bits(int unsigned lsb, int unsigned n);
    logic [DW-1:0] v;
    v = '0;
    for (int unsigned i = 0; i < DW; i++)
      if (i >= lsb && i < lsb + n) v[i] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/usb_irq_edge.sv
module usb_irq_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/usb_irq_src.sv
module usb_irq_src #(
  parameter int unsigned  W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hw_set_i,
  input  logic [W-1:0] sw_set_i,
  input  logic [W-1:0] sw_clr_i,
  output logic [W-1:0] src_o
);
  logic [W-1:0] src_q, src_d;

  // hardware set applied after clear: set wins
  always_comb src_d = ((src_q & ~sw_clr_i) | sw_set_i | hw_set_i) & VALID;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_d;
  end

  assign src_o = src_q;
endmodule

// File: rtl/usb_irq_mask.sv
module usb_irq_mask #(
  parameter int unsigned  W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= ((mask_q | set_i) & ~clr_i) & VALID;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/usb_irq_line.sv
module usb_irq_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic eoi_i,
  output logic irq_o
);
  logic armed_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (eoi_i) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (armed_q && pend_i) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b1;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap #(
  parameter int unsigned NUM_TX   = 5,
  parameter int unsigned TX_LSB   = 0,
  parameter int unsigned NUM_RX   = 4,
  parameter int unsigned RX_LSB   = 9,
  parameter int unsigned NUM_CORE = 9,
  parameter int unsigned CORE_LSB = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [usb_irq_pkg::AW-1:0]  addr_i,
  input  logic [usb_irq_pkg::DW-1:0]  wdata_i,
  output logic [usb_irq_pkg::DW-1:0]  rdata_o,
  input  logic [NUM_TX-1:0]           tx_evt_i,
  input  logic [NUM_RX-1:0]           rx_evt_i,
  input  logic [NUM_CORE-1:0]         core_evt_i,
  output logic                        irq_o
);
  import usb_irq_pkg::*;

  localparam logic [DW-1:0] TX_BITS   = field_bits(TX_LSB, NUM_TX);
  localparam logic [DW-1:0] RX_BITS   = field_bits(RX_LSB, NUM_RX);
  localparam logic [DW-1:0] CORE_BITS = field_bits(CORE_LSB, NUM_CORE);
  localparam logic [DW-1:0] VALID     = TX_BITS | RX_BITS | CORE_BITS;

  logic [DW-1:0] hw_lvl, hw_rise, src_q, mask_q, masked;
  logic [DW-1:0] sset, sclr, mset, mclr;
  wr_strb_t      wr;
  logic          eoi_wr, mclr_wr;

  always_comb begin
    hw_lvl = '0;
    hw_lvl[TX_LSB   +: NUM_TX]   = tx_evt_i;
    hw_lvl[RX_LSB   +: NUM_RX]   = rx_evt_i;
    hw_lvl[CORE_LSB +: NUM_CORE] = core_evt_i;
  end

  always_comb begin
    wr         = '0;
    wr.raw_set = req_i && we_i && addr_i == OFS_SET;
    wr.raw_clr = req_i && we_i && addr_i == OFS_CLR;
    wr.msk_set = req_i && we_i && addr_i == OFS_MSET;
    wr.msk_clr = req_i && we_i && addr_i == OFS_MCLR;
    wr.eoi     = req_i && we_i && addr_i == OFS_EOI;
  end

  assign sset    = wr.raw_set ? wdata_i : '0;
  assign sclr    = wr.raw_clr ? wdata_i : '0;
  assign mset    = wr.msk_set ? wdata_i : '0;
  assign mclr    = wr.msk_clr ? wdata_i : '0;
  assign eoi_wr  = wr.eoi;
  assign mclr_wr = wr.msk_clr;

  usb_irq_edge #(.W(DW)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (hw_lvl),
    .rise_o (hw_rise)
  );

  usb_irq_src #(.W(DW), .VALID(VALID)) i_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_set_i (hw_rise),
    .sw_set_i (sset),
    .sw_clr_i (sclr),
    .src_o    (src_q)
  );

  usb_irq_mask #(.W(DW), .VALID(VALID)) i_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mset),
    .clr_i  (mclr),
    .mask_o (mask_q)
  );

  assign masked = src_q & mask_q;

  usb_irq_line i_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (|masked),
    .eoi_i  (eoi_wr),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        OFS_RAW:    rdata_o = src_q;
        OFS_MASK:   rdata_o = mask_q;
        OFS_MASKED: rdata_o = masked;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/usb_irq_wrap_chk.sv
module usb_irq_wrap_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic          eoi_wr,
  input logic          mclr_wr,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] src_q,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] hw_rise,
  input logic [DW-1:0] valid_i
);
  assert_irq_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(src_q & mask_q)));

  assert_irq_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !eoi_wr) |=> irq_o);

  assert_eoi_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr |=> !irq_o);

  assert_hw_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(hw_rise & valid_i)) |=> ((src_q & $past(hw_rise & valid_i)) == $past(hw_rise & valid_i)));

  assert_mask_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_wr |=> ((mask_q & $past(wdata_i)) == '0));

  assert_src_holes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_q | mask_q) & ~valid_i) == '0);
endmodule

bind usb_irq_wrap usb_irq_wrap_chk #(.DW(usb_irq_pkg::DW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .eoi_wr  (eoi_wr),
  .mclr_wr (mclr_wr),
  .wdata_i (wdata_i),
  .src_q   (src_q),
  .mask_q  (mask_q),
  .hw_rise (hw_rise),
  .valid_i (VALID)
);

// File: tb/test_usb_irq_wrap.sv
`timescale 1ns/1ps
module test_usb_irq_wrap;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [4:0]  tx_evt;
  logic [3:0]  rx_evt;
  logic [8:0]  core_evt;
  logic        irq;
  int          total = 0;
  int          bad = 0;
  logic [31:0] valid_bits, rv, acc;

  always #2.5 clk = ~clk;

  usb_irq_wrap i_usb_irq_wrap (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
    .core_evt_i(core_evt), .irq_o(irq)
  );

  function automatic logic [31:0] calc_valid();
    logic [31:0] v = '0;
    for (int i = 0; i < 32; i++)
      if (i <= 4 || (i >= 9 && i <= 12) || (i >= 16 && i <= 24)) v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #0.5 d = rdata;
    req = 1'b0;
  endtask

  task automatic drive_evt(input logic [31:0] v);
    tx_evt = v[4:0]; rx_evt = v[12:9]; core_evt = v[24:16];
  endtask

  task automatic pulse(input logic [31:0] v);
    drive_evt(v);
    @(negedge clk);
    drive_evt('0);
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    valid_bits = calc_valid();
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    drive_evt('0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h20, rv); chk("R1 raw", rv, '0);
    rd(8'h2c, rv); chk("R1 mask", rv, '0);
    rd(8'h38, rv); chk("R1 masked", rv, '0);
    chk("R1 irq", {31'd0, irq}, '0);

    // R2 per-bit event edges
    for (int b = 0; b < 32; b++) begin
      if (valid_bits[b]) begin
        pulse(32'd1 << b);
        rd(8'h20, rv); chk("R2 event bit", rv, 32'd1 << b);
        wr(8'h28, 32'd1 << b);
        rd(8'h20, rv); chk("R2 cleared", rv, '0);
      end
    end
    drive_evt(32'd1 << 3);
    @(negedge clk);
    wr(8'h28, 32'hffff_ffff);
    @(negedge clk);
    rd(8'h20, rv); chk("R2 held level no reset", rv, '0);
    drive_evt('0);
    @(negedge clk);

    // R3 set sweep over all positions
    for (int b = 0; b < 32; b++) begin
      wr(8'h24, 32'd1 << b);
      rd(8'h20, rv); chk("R3 set bit", rv, (32'd1 << b) & valid_bits);
      wr(8'h28, 32'hffff_ffff);
    end
    wr(8'h24, 32'hffff_ffff);
    rd(8'h20, rv); chk("R3 set all", rv, valid_bits);

    // R4 selective clear
    wr(8'h28, 32'h0000_0203);
    rd(8'h20, rv); chk("R4 partial clear", rv, valid_bits & ~32'h0000_0203);
    wr(8'h28, 32'h0);
    rd(8'h20, rv); chk("R4 zero clear", rv, valid_bits & ~32'h0000_0203);
    wr(8'h28, 32'hffff_ffff);
    rd(8'h20, rv); chk("R4 clear all", rv, '0);

    // R5 event edge beats same-cycle clear
    drive_evt(32'd1 << 10);
    wr(8'h28, 32'd1 << 10);
    drive_evt('0);
    rd(8'h20, rv); chk("R5 set wins", rv, 32'd1 << 10);
    wr(8'h28, 32'hffff_ffff);

    // R6 mask set walk then alternating clears
    acc = '0;
    for (int b = 0; b < 32; b++) begin
      wr(8'h30, 32'd1 << b);
      acc |= (32'd1 << b);
      rd(8'h2c, rv); chk("R6 mask set", rv, acc & valid_bits);
    end
    wr(8'h34, 32'h5555_5555);
    rd(8'h2c, rv); chk("R6 mask clear", rv, valid_bits & 32'haaaa_aaaa);
    wr(8'h34, 32'h0);
    rd(8'h2c, rv); chk("R6 zero clear", rv, valid_bits & 32'haaaa_aaaa);

    // R7 masked view and write-only addresses
    wr(8'h24, 32'h0103_1213);
    rd(8'h38, rv); chk("R7 masked", rv, 32'h0103_1213 & valid_bits & 32'haaaa_aaaa);
    rd(8'h20, rv); chk("R7 raw", rv, 32'h0103_1213 & valid_bits);
    rd(8'h24, rv); chk("R7 set reads 0", rv, '0);
    rd(8'h28, rv); chk("R7 clr reads 0", rv, '0);
    rd(8'h30, rv); chk("R7 mset reads 0", rv, '0);
    rd(8'h34, rv); chk("R7 mclr reads 0", rv, '0);
    rd(8'h3c, rv); chk("R7 eoi reads 0", rv, '0);

    // clean line
    wr(8'h28, 32'hffff_ffff);
    wr(8'h34, 32'hffff_ffff);
    wr(8'h3c, 32'h0);
    @(negedge clk);
    chk("R9 idle after eoi", {31'd0, irq}, '0);

    // R8 unmasked source does not raise line
    wr(8'h24, 32'd1 << 2);
    repeat (3) @(negedge clk);
    chk("R8 unmasked quiet", {31'd0, irq}, '0);
    wr(8'h28, 32'hffff_ffff);

    // R8 assertion latency and hold
    wr(8'h30, 32'd1 << 17);
    wr(8'h24, 32'd1 << 17);
    chk("R8 not yet", {31'd0, irq}, '0);
    @(negedge clk);
    chk("R8 asserted", {31'd0, irq}, 32'd1);
    wr(8'h28, 32'd1 << 17);
    chk("R8 hold after clear", {31'd0, irq}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 still held", {31'd0, irq}, 32'd1);

    // R9 eoi with nothing pending
    wr(8'h3c, 32'h0);
    chk("R9 drop", {31'd0, irq}, '0);
    repeat (3) @(negedge clk);
    chk("R9 stays low", {31'd0, irq}, '0);
    wr(8'h24, 32'd1 << 17);
    chk("R9 not yet", {31'd0, irq}, '0);
    @(negedge clk);
    chk("R9 new request", {31'd0, irq}, 32'd1);
    // R9 eoi while pending
    wr(8'h3c, 32'h0);
    chk("R9 gap", {31'd0, irq}, '0);
    @(negedge clk);
    chk("R9 reassert", {31'd0, irq}, 32'd1);

    // R10 eoi data ignored
    wr(8'h3c, 32'hffff_ffff);
    chk("R10 gap", {31'd0, irq}, '0);
    @(negedge clk);
    chk("R10 reassert", {31'd0, irq}, 32'd1);
    rd(8'h20, rv); chk("R10 raw kept", rv, 32'd1 << 17);
    rd(8'h2c, rv); chk("R10 mask kept", rv, 32'd1 << 17);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule